// File: doc/BRIEF.md
# Multi-Enable Interrupt Source Aggregator

This block collects a parameterised set of level-sensitive interrupt lines. It turns them into one interrupt request for the processor. It also answers vector queries. A source can only become pending when its line is asserted and every enable assigned to it is active at the same moment. A source may have several enables: a mask bit, a priority field that is non-zero, or an enclosing group enable. The register file supplies these enables as a flat vector of slots.

Each source owns `MAX_EN` enable slots. The parameter `EN_REQ` gives the number of slots a source actually uses, which is its required enable count. The block keeps a registered count of pending sources. It raises the request while that count is non-zero.

Vector selection scans the pending sources from the lowest index upward. The vector of source `i` is `VEC_BASE + i*VEC_STEP`. The scan is suppressed completely when the processor's mask level is at its maximum. Source 0 is reserved and is never reported.

Top module: `intc_multi_en_agg`

## Requirements
- R1: A source `i` (with `i` ≥ 1) is pending exactly when its recorded level is 1 and all of its assigned enable slots are 1. Slot `j` of source `i` is `en_bits_i[i*MAX_EN+j]`. The assigned slots are `j < EN_REQ[i]`. By default the required counts for sources 1..7 are 3,1,2,3,1,2,3.
- R2: Enable slots at or above a source's required count have no effect on whether that source is pending.
- R3: Source 0 never becomes pending. It never raises the request and its vector is never reported, whatever its level and enables.
- R4: The request output goes high on the second rising edge after the inputs make the first source pending. It goes low on the second rising edge after the last pending source clears. It is still unchanged after the first edge.
- R5: When `imask_i` equals 4'hF, `vec_valid_o` is 0 and `vec_o` is 0 even if sources are pending. The request output is unaffected by the mask level.
- R6: Otherwise `vec_valid_o` is 1 and `vec_o` is `VEC_BASE + i*VEC_STEP` for the lowest-numbered pending source `i`. By default this is 0x400 + 0x20·i. It takes effect one rising edge after the inputs change.
- R7: When no source is pending, `vec_valid_o` is 0 and `vec_o` is 0.
- R8: Synchronous reset clears all level and enable state. While reset is held, all outputs are 0, even with every input asserted.
- R9: Holding a level input at its recorded value leaves the recorded state and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl_i | input | N_SRC | Raw level of each interrupt source |
| en_bits_i | input | N_SRC*MAX_EN | Enable slots, MAX_EN per source, source 0 in the low bits |
| imask_i | input | IMASK_W | Processor interrupt mask level |
| irq_req_o | output | 1 | Aggregate interrupt request, registered |
| vec_valid_o | output | 1 | A vector is available for the query |
| vec_o | output | VEC_W | Vector of the selected source, 0 when not valid |

## Verification
The assertions check several properties on every cycle. A pending source always has its recorded level set. Source 0 never becomes pending. The request can rise only from a zero pending count. The maximum mask level always forces an empty query. An invalid query always carries a zero vector. A held level leaves the recorded state alone. Only the bench scenarios can show the rest. These are the arithmetic of the vector table, the choice of the lowest index among several pending sources, the exact edges at which the request rises and falls, and the fact that unassigned enable slots are ignored.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_BLOCKED = 2'd1,
        PICK_FOUND   = 2'd2
    } pick_state_e;

    // Mask with the n lowest bits set.
    function automatic logic [31:0] low_ones(input int n);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < 32; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

    // Vector address of a source index.
    function automatic logic [31:0] vec_of(input logic [31:0] base,
                                           input logic [31:0] step,
                                           input int idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/intc_src_track.sv
module intc_src_track #(
    parameter int IDX    = 1,
    parameter int MAX_EN = 3,
    parameter int REQ    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_i,
    input  logic [MAX_EN-1:0] en_i,
    output logic              pend_o
);
    import intc_agg_pkg::*;

    localparam logic [31:0]       MASK32    = low_ones(REQ);
    localparam logic [MAX_EN-1:0] SLOT_MASK = MASK32[MAX_EN-1:0];

    logic              asrt_q;
    logic [MAX_EN-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            asrt_q <= 1'b0;
            en_q   <= '0;
        end else begin
            if (lvl_i != asrt_q) asrt_q <= lvl_i;
            en_q <= en_i & SLOT_MASK;
        end
    end

    generate
        if (IDX == 0) begin : g_reserved
            assign pend_o = 1'b0;
        end else begin : g_live
            assign pend_o = asrt_q && ($countones(en_q) == REQ);
        end
    endgenerate

    // R1: pending implies the recorded level is set
    p_pend_needs_level_r1: assert property (@(posedge clk) disable iff (rst)
        pend_o |-> asrt_q);

    // R9: a held level keeps the recorded state
    p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (lvl_i == asrt_q) |=> $stable(asrt_q));

endmodule

// File: rtl/intc_pend_count.sv
module intc_pend_count #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend_i,
    output logic             irq_o
);
    localparam int CNT_W = $clog2(N_SRC + 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    always_comb begin
        cnt_d = '0;
        for (int k = 0; k < N_SRC; k++) begin
            cnt_d = cnt_d + CNT_W'(pend_i[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= (cnt_d != '0);
        end
    end

    assign irq_o = irq_q;

    // R4: the request rises only when the count leaves zero
    p_rise_from_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(cnt_q) == '0 && cnt_q != '0));

    // R3: the count never covers the reserved source
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(N_SRC - 1));

endmodule

// File: rtl/intc_vec_pick.sv
module intc_vec_pick #(
    parameter int          N_SRC    = 8,
    parameter int          VEC_W    = 12,
    parameter int          IMASK_W  = 4,
    parameter logic [31:0] VEC_BASE = 32'h400,
    parameter logic [31:0] VEC_STEP = 32'h20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   pend_i,
    input  logic [IMASK_W-1:0] imask_i,
    output logic               valid_o,
    output logic [VEC_W-1:0]   vec_o
);
    import intc_agg_pkg::*;

    localparam logic [IMASK_W-1:0] MASK_MAX = '1;

    pick_state_e      state;
    logic [VEC_W-1:0] sel_vec;

    always_comb begin
        state   = PICK_NONE;
        sel_vec = '0;
        for (int k = N_SRC - 1; k >= 1; k--) begin
            if (pend_i[k]) begin
                state   = PICK_FOUND;
                sel_vec = VEC_W'(vec_of(VEC_BASE, VEC_STEP, k));
            end
        end
        if (imask_i == MASK_MAX) begin
            state   = PICK_BLOCKED;
            sel_vec = '0;
        end
    end

    assign valid_o = (state == PICK_FOUND);
    assign vec_o   = valid_o ? sel_vec : '0;

    // R5: maximum mask level empties the query
    p_mask_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (imask_i == MASK_MAX) |-> (!valid_o && vec_o == '0));

    // R7: an empty query carries a zero vector
    p_zero_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (vec_o == '0));

endmodule

// File: rtl/intc_multi_en_agg.sv
module intc_multi_en_agg #(
    parameter int          N_SRC    = 8,
    parameter int          MAX_EN   = 3,
    parameter int          VEC_W    = 12,
    parameter int          IMASK_W  = 4,
    parameter logic [31:0] VEC_BASE = 32'h400,
    parameter logic [31:0] VEC_STEP = 32'h20,
    parameter logic [N_SRC*$clog2(MAX_EN+1)-1:0] EN_REQ = 16'hE79C
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        irq_lvl_i,
    input  logic [N_SRC*MAX_EN-1:0] en_bits_i,
    input  logic [IMASK_W-1:0]      imask_i,
    output logic                    irq_req_o,
    output logic                    vec_valid_o,
    output logic [VEC_W-1:0]        vec_o
);
    localparam int CW = $clog2(MAX_EN + 1);

    logic [N_SRC-1:0] pend_vec;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            intc_src_track #(
                .IDX    (g),
                .MAX_EN (MAX_EN),
                .REQ    (int'(EN_REQ[g*CW +: CW]))
            ) u_track (
                .clk    (clk),
                .rst    (rst),
                .lvl_i  (irq_lvl_i[g]),
                .en_i   (en_bits_i[g*MAX_EN +: MAX_EN]),
                .pend_o (pend_vec[g])
            );
        end
    endgenerate

    intc_pend_count #(
        .N_SRC (N_SRC)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_vec),
        .irq_o  (irq_req_o)
    );

    intc_vec_pick #(
        .N_SRC    (N_SRC),
        .VEC_W    (VEC_W),
        .IMASK_W  (IMASK_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_pick (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend_vec),
        .imask_i (imask_i),
        .valid_o (vec_valid_o),
        .vec_o   (vec_o)
    );

    // R3: reserved source never pending
    p_src0_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !pend_vec[0]);

    // R4: any pending source is followed by a raised request
    p_req_follows_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_vec != '0) |=> irq_req_o);

    // R8: outputs quiet during reset once the first edge has passed
    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(rst) |-> !irq_req_o);

endmodule

// File: tb/intc_multi_en_agg_tb.sv
module intc_multi_en_agg_tb;
    localparam int N   = 8;
    localparam int ME  = 3;
    localparam int VW  = 12;
    localparam int REQS [N] = '{0, 3, 1, 2, 3, 1, 2, 3};

    typedef struct {
        logic          irq;
        logic          valid;
        logic [VW-1:0] vec;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      lvl = '0;
    logic [N*ME-1:0]   en  = '0;
    logic [3:0]        imask = 4'h0;
    logic              irq_req;
    logic              vvalid;
    logic [VW-1:0]     vec;

    int   total = 0;
    int   bad   = 0;
    exp_t sbq[$];

    always #2 clk = ~clk;

    intc_multi_en_agg u_dut (
        .clk         (clk),
        .rst         (rst),
        .irq_lvl_i   (lvl),
        .en_bits_i   (en),
        .imask_i     (imask),
        .irq_req_o   (irq_req),
        .vec_valid_o (vvalid),
        .vec_o       (vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [N-1:0] l, input logic [N*ME-1:0] e,
                                   input logic [3:0] m, input string tag);
        exp_t r;
        int   low;
        low = 0;
        r.irq = 1'b0;
        for (int i = N - 1; i >= 1; i--) begin
            logic ok;
            ok = l[i];
            for (int j = 0; j < REQS[i]; j++) if (!e[i*ME+j]) ok = 1'b0;
            if (ok) begin
                low   = i;
                r.irq = 1'b1;
            end
        end
        r.valid = (low != 0) && (m != 4'hF);
        r.vec   = r.valid ? VW'(32'h400 + 32'h20 * low) : '0;
        r.tag   = tag;
        return r;
    endfunction

    // Monitor: pops expected items and compares at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t x;
            x = sbq.pop_front();
            chk({x.tag, " irq"},   32'(irq_req), 32'(x.irq));
            chk({x.tag, " valid"}, 32'(vvalid),  32'(x.valid));
            chk({x.tag, " vec"},   32'(vec),     32'(x.vec));
        end
    end

    // Driver: apply inputs, let both pipeline stages settle, queue expectation.
    task automatic step(input logic [N-1:0] l, input logic [N*ME-1:0] e,
                        input logic [3:0] m, input string tag);
        @(negedge clk);
        lvl = l; en = e; imask = m;
        @(posedge clk);
        @(posedge clk);
        #1;
        sbq.push_back(model(l, e, m, tag));
        @(negedge clk);
    endtask

    function automatic logic [N*ME-1:0] slots(input int src, input logic [ME-1:0] b);
        logic [N*ME-1:0] v;
        v = '0;
        v[src*ME +: ME] = b;
        return v;
    endfunction

    initial begin
        logic [N*ME-1:0] e_all;
        e_all = '1;
        lvl = '1; en = e_all; imask = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset irq",   32'(irq_req), 0);
        chk("R8 reset valid", 32'(vvalid),  0);
        chk("R8 reset vec",   32'(vec),     0);
        lvl = '0; en = '0; rst = 1'b0;
        step('0, '0, 4'h0, "R7 idle");

        // R4/R6 edge timing on source 2 (one slot required)
        @(negedge clk);
        lvl = 8'h04; en = slots(2, 3'b001);
        @(negedge clk);
        chk("R6 vec after one edge", 32'(vec), 32'h440);
        chk("R4 irq still low after one edge", 32'(irq_req), 0);
        @(negedge clk);
        chk("R4 irq high after two edges", 32'(irq_req), 1);

        step(8'h04, slots(2, 3'b001), 4'h0, "R1 src2 pending");
        step(8'h04, slots(2, 3'b001), 4'h0, "R9 held level");
        step(8'h10, slots(4, 3'b011), 4'h0, "R1 src4 partial enables");
        step(8'h10, slots(4, 3'b111), 4'h0, "R1 src4 all enables");
        step(8'h20, slots(5, 3'b110), 4'h0, "R2 src5 unassigned only");
        step(8'h20, slots(5, 3'b111), 4'h0, "R2 src5 extra slots set");
        step(8'h01, slots(0, 3'b111), 4'h0, "R3 src0 ignored");
        step(8'hC8, slots(3, 3'b011) | slots(6, 3'b011) | slots(7, 3'b111),
             4'h0, "R6 lowest of three");
        step(8'hC0, slots(3, 3'b011) | slots(6, 3'b011) | slots(7, 3'b111),
             4'h0, "R6 next lowest");
        step(8'hC0, slots(6, 3'b011) | slots(7, 3'b111), 4'hF, "R5 mask max");
        step(8'hC0, slots(6, 3'b011) | slots(7, 3'b111), 4'hE, "R5 mask below max");

        // R4 fall timing
        @(negedge clk);
        lvl = '0;
        @(negedge clk);
        chk("R4 irq still high after one edge", 32'(irq_req), 1);
        chk("R7 vec zero once idle", 32'(vec), 0);
        @(negedge clk);
        chk("R4 irq low after two edges", 32'(irq_req), 0);

        step('0, e_all, 4'h0, "R7 enables without levels");
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule